// File: doc/BRIEF.md
# Receive Path Digital Attenuator with Half-Level Switch

This block attenuates the 16-bit signed samples of a receive voice path. A 7-bit loss code picks a loss of 0 dB to 12 dB in 0.1 dB steps. Each sample is multiplied by an unsigned Q1.15 factor, rounded to nearest and saturated to 16 bits. The factor is formed from two small constant tables: one for whole decibels and one for tenths.

A separate control input adds a further 6 dB of loss by shifting the scaled result right by one bit. The programmed code does not have to be rewritten to do this. The total loss must stay within 12 dB. So while the extra 6 dB is on, the programmed part is capped at 6 dB (code 60), and a sticky flag records that the cap was used.

The output is registered. It appears one clock after the input strobe, together with its own strobe.

Top module: `rx_loss_atten`

## Requirements
- R1: For an effective code c, let q = c/10 (integer division) and u = c%10. Define C(q) = round(32768·10^(−q/20)), F(u) = round(32768·10^(−u/200)) and M = (C·F + 16384) >> 15. Without the extra loss, the output is (x·M + 16384) >>> 15, which rounds to nearest with halves going up. Code 0 gives M = 32768, which passes the sample through unchanged.
- R2: Loss codes 121 to 127 act exactly as code 120 (12 dB).
- R3: As the code rises from 0 to 120, the output for a full-scale positive input never increases.
- R4: When extra_att is 1, the R1 result is arithmetically shifted right by one bit (floor) before it is output.
- R5: When extra_att is 1 and the code after the R2 limit is above 60, code 60 is used instead.
- R6: clamp_err rises in the cycle after an accepted sample that has extra_att = 1 and a code above 60. Once set, it stays at 1 until reset. No other condition sets it.
- R7: out_valid is in_valid delayed by one clock. out_sample changes only in a cycle where out_valid is 1, and otherwise holds its value.
- R8: After a synchronous active-low reset, out_valid is 0, out_sample is 0 and clamp_err is 0.
- R9: The magnitude of an output never exceeds the magnitude of the input that produced it. Results are saturated to the 16-bit signed range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 16 | Signed input sample |
| loss_code | input | 7 | Loss in 0.1 dB units |
| extra_att | input | 1 | Adds 6 dB of loss when 1 |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | 16 | Signed attenuated sample |
| clamp_err | output | 1 | Sticky flag: the programmed loss was capped |

## Verification
The bench sweeps every code from 0 to 127 at both full-scale extremes. A wrong entry in either table, or a missing limit above code 120, shows up as a mismatch, and a reversed table breaks the monotonic sweep. The extra-loss tests use odd negative values, where a shift that rounds toward zero instead of down gives a result one too high. They also use codes just above and just below 60: a design without the cap lets the loss go past 12 dB, and a flag that is not sticky, or that fires at code 60, is caught. Samples are held between strobes so that an output register that follows its input without a strobe is exposed.

// File: rtl/rx_loss_atten.sv
module rx_loss_atten #(
  parameter int MAX_CODE  = 120,
  parameter int HALF_CODE = 60
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [15:0] in_sample,
  input  logic [6:0]  loss_code,
  input  logic        extra_att,
  output logic        out_valid,
  output logic [15:0] out_sample,
  output logic        clamp_err
);
  localparam int FRAC = 15;

  function automatic logic [15:0] coarse_f(input logic [3:0] q);
    case (q)
      4'd0:    coarse_f = 16'd32768;
      4'd1:    coarse_f = 16'd29205;
      4'd2:    coarse_f = 16'd26029;
      4'd3:    coarse_f = 16'd23198;
      4'd4:    coarse_f = 16'd20675;
      4'd5:    coarse_f = 16'd18427;
      4'd6:    coarse_f = 16'd16423;
      4'd7:    coarse_f = 16'd14637;
      4'd8:    coarse_f = 16'd13045;
      4'd9:    coarse_f = 16'd11627;
      4'd10:   coarse_f = 16'd10362;
      4'd11:   coarse_f = 16'd9235;
      default: coarse_f = 16'd8231;
    endcase
  endfunction

  function automatic logic [15:0] fine_f(input logic [3:0] u);
    case (u)
      4'd0:    fine_f = 16'd32768;
      4'd1:    fine_f = 16'd32393;
      4'd2:    fine_f = 16'd32022;
      4'd3:    fine_f = 16'd31656;
      4'd4:    fine_f = 16'd31293;
      4'd5:    fine_f = 16'd30935;
      4'd6:    fine_f = 16'd30581;
      4'd7:    fine_f = 16'd30231;
      4'd8:    fine_f = 16'd29885;
      default: fine_f = 16'd29543;
    endcase
  endfunction

  logic [6:0]         code_lim, code_eff;
  logic               over;
  logic [3:0]         tens, units;
  logic [31:0]        mprod;
  logic [16:0]        mult;
  logic signed [33:0] prod, scaled;
  logic [15:0]        sat, shaped;

  assign code_lim = (loss_code > 7'(MAX_CODE)) ? 7'(MAX_CODE) : loss_code;
  assign over     = extra_att && (code_lim > 7'(HALF_CODE));
  assign code_eff = over ? 7'(HALF_CODE) : code_lim;
  assign tens     = 4'(code_eff / 7'd10);
  assign units    = 4'(code_eff % 7'd10);

  assign mprod = {16'd0, coarse_f(tens)} * {16'd0, fine_f(units)};
  assign mult  = 17'((mprod + 32'd16384) >> FRAC);

  assign prod   = 34'(signed'(in_sample)) * 34'(signed'({1'b0, mult}));
  assign scaled = (prod + 34'sd16384) >>> FRAC;

  always_comb begin
    if (scaled > 34'sd32767)       sat = 16'h7fff;
    else if (scaled < -34'sd32768) sat = 16'h8000;
    else                           sat = scaled[15:0];
  end

  assign shaped = extra_att ? {sat[15], sat[15:1]} : sat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
      clamp_err  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sample <= shaped;
        if (over) clamp_err <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rx_loss_atten_chk.sv
module rx_loss_atten_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [15:0] in_sample,
  input logic [6:0]  loss_code,
  input logic        extra_att,
  input logic        out_valid,
  input logic [15:0] out_sample,
  input logic        clamp_err
);
  function automatic logic [16:0] mag(input logic [15:0] v);
    mag = v[15] ? 17'(-signed'({v[15], v})) : {1'b0, v};
  endfunction

  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r7_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_sample));
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_err |=> clamp_err);
  a_r6_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clamp_err) |-> $past(in_valid && extra_att && loss_code > 7'd60));
  a_r9_no_gain: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> mag(out_sample) <= mag($past(in_sample)));
  a_r4_half_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(extra_att) |-> (out_sample[15] == out_sample[14]));
endmodule

bind rx_loss_atten rx_loss_atten_chk chk_i (.*);

// File: tb/rx_loss_atten_tb_top.sv
module rx_loss_atten_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_sample = '0;
  logic [6:0]  loss_code = '0;
  logic        extra_att = 1'b0;
  logic        out_valid;
  logic [15:0] out_sample;
  logic        clamp_err;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rx_loss_atten dut_i (.*);

  function automatic longint rnd(real v);
    return longint'($floor(v + 0.5));
  endfunction

  function automatic longint ref_mult(int c);
    longint cq, fu;
    cq = rnd(32768.0 * (10.0 ** (-(c / 10) / 20.0)));
    fu = rnd(32768.0 * (10.0 ** (-(c % 10) / 200.0)));
    return (cq * fu + 16384) >>> 15;
  endfunction

  function automatic logic [15:0] ref_out(logic [15:0] x, int code, bit ext);
    longint y;
    int c;
    c = (code > 120) ? 120 : code;
    if (ext && c > 60) c = 60;
    y = (longint'(signed'(x)) * ref_mult(c) + 16384) >>> 15;
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    if (ext) y = y >>> 1;
    return 16'(y);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(logic [15:0] x, int code, bit ext, string req);
    @(negedge clk);
    in_valid = 1'b1; in_sample = x; loss_code = 7'(code); extra_att = ext;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, 32'(out_valid), 32'd1);
    check({req, " data"}, 32'(out_sample), 32'(ref_out(x, code, ext)));
  endtask

  task automatic t_reset();
    check("R8 valid", 32'(out_valid), 0);
    check("R8 data", 32'(out_sample), 0);
    check("R8 err", 32'(clamp_err), 0);
  endtask

  task automatic t_unity();
    send(16'h7fff, 0, 0, "R1 unity max");
    check("R1 unity max value", 32'(out_sample), 32'h7fff);
    send(16'h8000, 0, 0, "R1 unity min");
    check("R1 unity min value", 32'(out_sample), 32'h8000);
    send(16'h1234, 0, 0, "R1 unity mid");
  endtask

  task automatic t_sweep();
    logic [15:0] prev;
    prev = 16'h7fff;
    for (int c = 0; c < 128; c++) begin
      send(16'h7fff, c, 0, "R1 R2 sweep pos");
      if (c <= 120) begin
        check("R3 monotonic", 32'(out_sample <= prev), 1);
        prev = out_sample;
      end
      send(16'h8000, c, 0, "R1 R2 sweep neg");
    end
    send(16'h4000, 127, 0, "R2 top code");
    check("R2 same as 120", 32'(out_sample), 32'(ref_out(16'h4000, 120, 0)));
    check("R2 no error", 32'(clamp_err), 0);
  endtask

  task automatic t_mixed();
    send(16'hfffd, 37, 0, "R1 small neg");
    send(16'h0001, 5, 0, "R1 tiny");
    send(16'hd00f, 83, 0, "R1 neg mid");
    send(16'h6a5b, 119, 0, "R1 near top");
    send(16'h7fff, 12, 0, "R9 no gain");
  endtask

  task automatic t_extra();
    send(16'hffff, 0, 1, "R4 minus one");
    check("R4 floor", 32'(out_sample), 32'hffff);
    send(16'h8001, 0, 1, "R4 odd neg");
    check("R4 odd neg value", 32'(out_sample), 32'hc000);
    send(16'h7fff, 0, 1, "R4 max");
    check("R4 max value", 32'(out_sample), 32'h3fff);
    send(16'h7fff, 60, 1, "R5 at limit");
    check("R6 not at 60", 32'(clamp_err), 0);
  endtask

  task automatic t_clamp();
    send(16'h7fff, 61, 1, "R5 just over");
    check("R5 capped to 60", 32'(out_sample), 32'(ref_out(16'h7fff, 60, 1)));
    check("R6 set", 32'(clamp_err), 1);
    send(16'h5555, 20, 0, "R6 later sample");
    check("R6 sticky", 32'(clamp_err), 1);
    send(16'h9000, 127, 1, "R5 top code");
  endtask

  task automatic t_hold();
    logic [15:0] last;
    send(16'h2222, 10, 0, "R7 base");
    last = out_sample;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      in_sample = 16'(16'h1111 * (i + 3));
      loss_code = 7'(i * 30);
      extra_att = 1'(i);
    end
    @(negedge clk);
    check("R7 no valid", 32'(out_valid), 0);
    check("R7 held", 32'(out_sample), 32'(last));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_unity();
    t_mixed();
    t_extra();
    t_hold();
    t_sweep();
    t_clamp();
    rst_n = 1'b0;
    @(negedge clk);
    t_reset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule